// File: doc/BRIEF.md
# Amplifier Fault Supervisor Controller

This block sits beside a multi-channel PWM power stage and decides, every system clock, whether each output stage may switch or must be held in high impedance. It collects supply undervoltage flags, a power-on-reset flag, over-temperature warning and shutdown flags, per-channel overload flags, and an activity check on an external oscillator that applies only in slave mode. From these it drives one enable per channel, an active-low fault pin and an active-low warning pin.

Faults fall into two scopes. A global fault stops every channel. A channel fault stops only its own channel. Faults also differ in how they end. Over-temperature shutdown and channel overload are latched: they stay active until the active-low reset input has been driven low and then released. Supply faults, power-on reset and oscillator loss clear by themselves once the condition goes away. Holding reset low stops all channels and forces the fault pin high, whatever faults are present. The thermal warning lights only the warning pin and leaves switching untouched. The comparators, the analog sensing and the PWM generation are outside this block.

Top module: `amp_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, and for the first two rising clock edges after it goes high, `ch_en` is all zero and both `fault_n` and `otw_n` are 1, for any value of the fault inputs.
- R2: All outputs are registered. Outside reset, each rising edge loads them from the inputs present at that edge. With no fault present, every `ch_en` bit is 1, `fault_n` is 1 and `otw_n` is 1.
- R3: If any `uv_flag` bit or `por_flag` is 1 at an edge, that edge clears all `ch_en` bits and drives `fault_n` to 0. Once the inputs return to 0, the next edge restores both outputs, with no reset needed.
- R4: `ote_flag` high at an edge clears all `ch_en` bits and drives `fault_n` to 0 from that edge on. The condition stays latched after the flag falls, until a reset. If the flag is still high when reset is released, the first functional edge latches it again.
- R5: `ch_ovl[i]` high at an edge clears only `ch_en[i]` and drives `fault_n` to 0. Every other channel keeps its enable. The condition stays latched until a reset.
- R6: `otw_n` is the inverse of `otw_flag` as sampled at the previous edge. `otw_flag` has no effect on `ch_en` or `fault_n`.
- R7: When `slave_mode` is 1, the block counts the consecutive edges at which `osc_in` equals its value at the edge before; a level change or `slave_mode` at 0 resets this count to zero. Once the count reaches OSC_TIMEOUT, each edge at which `slave_mode` is 1 clears all `ch_en` bits. `fault_n` is not affected. The fault clears on its own: channels return at the second edge after `osc_in` changes level.
- R8: When `slave_mode` is 0, `osc_in` activity or its absence has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asynchronous assert, synchronized release; clears latched faults |
| uv_flag | input | NUM_SUP | Supply undervoltage flags, one per supply |
| por_flag | input | 1 | Power-on-reset flag |
| otw_flag | input | 1 | Over-temperature warning flag |
| ote_flag | input | 1 | Over-temperature shutdown flag |
| ch_ovl | input | NUM_CH | Per-channel overload flags |
| slave_mode | input | 1 | 1 selects the external oscillator, enabling its activity check |
| osc_in | input | 1 | External oscillator level, sampled on clk |
| ch_en | output | NUM_CH | 1 = channel switches, 0 = channel held high impedance |
| fault_n | output | 1 | Active-low fault indication |
| otw_n | output | 1 | Active-low over-temperature warning |

## Verification
The bench builds the block with NUM_CH=3, NUM_SUP=2 and OSC_TIMEOUT=6. Three channels put healthy channels on both sides of an overloaded middle channel, so any leak of a channel fault into its neighbours shows up. A six-edge timeout lets the bench place oscillator pauses one edge shorter than, exactly equal to, and longer than the limit in a short run. It also lets the bench switch slave mode on with a quiet oscillator and watch the count start from zero. Reset pulses are applied with the shutdown flag both cleared and still high, which covers latch clearing and immediate re-latching.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;

  // Sources that take every channel down at once
  typedef struct packed {
    logic supply;   // undervoltage or power-on reset, self-clearing
    logic thermal;  // over-temperature shutdown, latched
    logic stuck;    // external oscillator idle in slave mode, unreported
  } glob_src_t;

endpackage

// File: rtl/afs_rst_sync.sv
module afs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/afs_sticky.sv
module afs_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] act_o
);

  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  // Active at once on the raw flag, held afterwards
  assign act_o = hold_q | set_i;

endmodule

// File: rtl/afs_osc_watch.sv
module afs_osc_watch #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_i,
  input  logic osc_i,
  output logic stuck_o
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic          osc_q;
  logic [CW-1:0] idle_q;
  logic [CW-1:0] idle_d;
  logic          toggled;

  always_comb begin
    toggled = osc_i ^ osc_q;
    if (!slave_i || toggled) begin
      idle_d = '0;
    end else if (idle_q == LIMIT) begin
      idle_d = idle_q;
    end else begin
      idle_d = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q  <= 1'b0;
      idle_q <= '0;
    end else begin
      osc_q  <= osc_i;
      idle_q <= idle_d;
    end
  end

  assign stuck_o = slave_i && (idle_q == LIMIT);

endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor #(
  parameter int NUM_CH      = 4,
  parameter int NUM_SUP     = 2,
  parameter int OSC_TIMEOUT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SUP-1:0] uv_flag,
  input  logic               por_flag,
  input  logic               otw_flag,
  input  logic               ote_flag,
  input  logic [NUM_CH-1:0]  ch_ovl,
  input  logic               slave_mode,
  input  logic               osc_in,
  output logic [NUM_CH-1:0]  ch_en,
  output logic               fault_n,
  output logic               otw_n
);

  import amp_fault_pkg::*;

  logic              rst_sync_n;
  logic              ote_act;
  logic [NUM_CH-1:0] ch_act;
  logic              osc_stuck;
  glob_src_t         glob;

  logic [NUM_CH-1:0] ch_en_d;
  logic              fault_n_d;
  logic              otw_n_d;

  afs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  afs_sticky #(.W(1)) u_ote_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (ote_flag),
    .act_o (ote_act)
  );

  afs_sticky #(.W(NUM_CH)) u_ch_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (ch_ovl),
    .act_o (ch_act)
  );

  afs_osc_watch #(.TIMEOUT(OSC_TIMEOUT)) u_osc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .slave_i (slave_mode),
    .osc_i   (osc_in),
    .stuck_o (osc_stuck)
  );

  always_comb begin
    glob.supply  = (|uv_flag) | por_flag;
    glob.thermal = ote_act;
    glob.stuck   = osc_stuck;
    ch_en_d      = {NUM_CH{~(|glob)}} & ~ch_act;
    // Oscillator loss is deliberately left off the fault pin
    fault_n_d    = ~(glob.supply | glob.thermal | (|ch_act));
    otw_n_d      = ~otw_flag;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ch_en   <= '0;
      fault_n <= 1'b1;
      otw_n   <= 1'b1;
    end else begin
      ch_en   <= ch_en_d;
      fault_n <= fault_n_d;
      otw_n   <= otw_n_d;
    end
  end

endmodule

// File: rtl/afs_checker.sv
module afs_checker #(
  parameter int NUM_CH  = 4,
  parameter int NUM_SUP = 2
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_SUP-1:0] uv_flag,
  input logic               por_flag,
  input logic               otw_flag,
  input logic               ote_flag,
  input logic [NUM_CH-1:0]  ch_ovl,
  input logic [NUM_CH-1:0]  ch_en,
  input logic               fault_n,
  input logic               otw_n
);

  // High from the edge after the first functional load onwards
  logic live_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  // R3
  supply_off_chk: assert property (@(posedge clk) disable iff (!live_q)
    ($past(|uv_flag) || $past(por_flag)) |-> (ch_en == '0 && !fault_n));

  // R4
  ote_latch_chk: assert property (@(posedge clk) disable iff (!live_q)
    $past(ote_flag, 2) |-> (ch_en == '0 && !fault_n));

  // R6
  warn_pin_chk: assert property (@(posedge clk) disable iff (!live_q)
    otw_n == !$past(otw_flag));

  // R2
  quiet_run_chk: assert property (@(posedge clk) disable iff (!live_q)
    !fault_n |-> (ch_en != {NUM_CH{1'b1}}));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      // R5
      ch_ovl_off_chk: assert property (@(posedge clk) disable iff (!live_q)
        $past(ch_ovl[gi]) |-> (!ch_en[gi] && !fault_n));
    end
  endgenerate

endmodule

bind amp_fault_supervisor afs_checker #(.NUM_CH(NUM_CH), .NUM_SUP(NUM_SUP)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .uv_flag    (uv_flag),
  .por_flag   (por_flag),
  .otw_flag   (otw_flag),
  .ote_flag   (ote_flag),
  .ch_ovl     (ch_ovl),
  .ch_en      (ch_en),
  .fault_n    (fault_n),
  .otw_n      (otw_n)
);

// File: tb/amp_fault_supervisor_tb.sv
module amp_fault_supervisor_tb;

  localparam int NC = 3;
  localparam int NS = 2;
  localparam int TO = 6;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] uv_flag;
  logic          por_flag, otw_flag, ote_flag;
  logic [NC-1:0] ch_ovl;
  logic          slave_mode, osc_in;
  logic [NC-1:0] ch_en;
  logic          fault_n, otw_n;

  amp_fault_supervisor #(.NUM_CH(NC), .NUM_SUP(NS), .OSC_TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .por_flag(por_flag),
    .otw_flag(otw_flag), .ote_flag(ote_flag), .ch_ovl(ch_ovl),
    .slave_mode(slave_mode), .osc_in(osc_in),
    .ch_en(ch_en), .fault_n(fault_n), .otw_n(otw_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    armed  = 0;
  string tag    = "R1";

  // Behavioural reference model
  int            since_rel;
  bit            m_ote;
  bit [NC-1:0]   m_ch;
  int            m_idle;
  bit            m_osc;
  bit [NC-1:0]   x_en;
  bit            x_fault_n, x_otw_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rel = 0;
      m_ote = 0; m_ch = '0; m_idle = 0; m_osc = 0;
      x_en = '0; x_fault_n = 1; x_otw_n = 1;
    end else if (since_rel < 2) begin
      since_rel++;
      m_ote = 0; m_ch = '0; m_idle = 0; m_osc = 0;
      x_en = '0; x_fault_n = 1; x_otw_n = 1;
    end else begin
      bit supply, stuck, all_off;
      supply = (uv_flag != 0) || por_flag;
      m_ote  = m_ote || ote_flag;
      m_ch   = m_ch | ch_ovl;
      stuck  = slave_mode && (m_idle >= TO);
      all_off = supply || m_ote || stuck;
      for (int i = 0; i < NC; i++) x_en[i] = !all_off && !m_ch[i];
      x_fault_n = !(supply || m_ote || (m_ch != 0));
      x_otw_n   = !otw_flag;
      if (!slave_mode || (osc_in != m_osc)) m_idle = 0;
      else if (m_idle < TO) m_idle++;
      m_osc = osc_in;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (ch_en !== x_en) begin
        errors++;
        $display("FAIL %s ch_en actual=%b expected=%b t=%0t", tag, ch_en, x_en, $time);
      end
      checks++;
      if (fault_n !== x_fault_n) begin
        errors++;
        $display("FAIL %s fault_n actual=%b expected=%b t=%0t", tag, fault_n, x_fault_n, $time);
      end
      checks++;
      if (otw_n !== x_otw_n) begin
        errors++;
        $display("FAIL %s otw_n actual=%b expected=%b t=%0t", tag, otw_n, x_otw_n, $time);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulse_reset(int low_cycles);
    rst_n = 1'b0;
    step(low_cycles);
    rst_n = 1'b1;
  endtask

  task automatic hold_osc(int n);
    step(n);
  endtask

  task automatic toggle_osc(int n);
    repeat (n) begin
      osc_in = ~osc_in;
      step(1);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b1; uv_flag = '0; por_flag = 0; otw_flag = 0; ote_flag = 0;
    ch_ovl = '0; slave_mode = 0; osc_in = 0;
    #2 rst_n = 1'b0;
    #1 armed = 1;

    // R1: faults present during reset must not reach the pins
    tag = "R1";
    ote_flag = 1; uv_flag = 2'b10; otw_flag = 1; ch_ovl = 3'b101;
    step(4);
    ote_flag = 0; uv_flag = '0; otw_flag = 0; ch_ovl = '0;
    rst_n = 1'b1;
    step(3);

    // R2: quiet run, all channels switching
    tag = "R2";
    step(4);

    // R3: undervoltage on each supply, then power-on reset
    tag = "R3";
    uv_flag = 2'b10; step(3);
    uv_flag = 2'b00; step(2);
    uv_flag = 2'b01; step(1);
    uv_flag = 2'b00; step(2);
    por_flag = 1; step(2);
    por_flag = 0; step(3);

    // R6: warning only on its own pin
    tag = "R6";
    otw_flag = 1; step(3);
    otw_flag = 0; step(2);

    // R5: one-cycle overload on the middle channel stays latched
    tag = "R5";
    ch_ovl = 3'b010; step(1);
    ch_ovl = 3'b000; step(5);
    ch_ovl = 3'b100; step(1);
    ch_ovl = 3'b000; step(3);
    pulse_reset(2);
    step(5);

    // R4: thermal shutdown latches, clears on reset, re-latches if still high
    tag = "R4";
    ote_flag = 1; step(1);
    ote_flag = 0; step(6);
    pulse_reset(1);
    step(4);
    ote_flag = 1; step(2);
    pulse_reset(2);
    step(4);
    ote_flag = 0; step(4);
    pulse_reset(1);
    step(5);

    // R7: oscillator activity check in slave mode
    tag = "R7";
    slave_mode = 1;
    toggle_osc(8);
    hold_osc(TO - 1);   // one short of the limit
    toggle_osc(2);
    hold_osc(TO);       // exactly the limit
    toggle_osc(1);
    hold_osc(TO + 4);   // beyond the limit
    toggle_osc(3);
    hold_osc(2);
    slave_mode = 0; step(3);
    slave_mode = 1; hold_osc(TO + 3);
    toggle_osc(4);

    // R8: oscillator ignored in master mode
    tag = "R8";
    slave_mode = 0;
    hold_osc(3 * TO);
    toggle_osc(5);
    hold_osc(TO + 2);

    armed = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule